// File: doc/BRIEF.md
# Clock Output Power-Down Gating Controller

This block sits between a set of already-generated clocks and the chip pins that carry them. Each output (host CPU clock, memory clocks, hub clock, bus clock, interrupt-controller clock, fixed 48 MHz clock and reference clock) has its own source clock. The block passes each source through to its pin, or parks that pin low, depending on three things:

- an asynchronous active-low power-down input;
- a per-output run bit;
- one global bit that floats every pin.

Power-down is not acted on at once. The power-down input is first synchronised into the CPU clock domain. It is accepted only when it is seen low on two consecutive CPU-clock rising edges. Once it is accepted, each output stops on its own next falling edge, so no high pulse is ever cut short. While the block is powered down it also raises a request to stop the crystal oscillator and a request to stop the VCOs. When the power-down input returns high, the requests drop and every output restarts in its low phase, so its first pulse has full width.

Each run bit and the power-down decision are carried into the domain of the output they control. That output's gate changes only while its clock is low. One output is the free-running memory clock, which ignores its run bit.

Top module: `clk_park_ctrl`

## Requirements
- R1: While `rst` is high, every `clk_out` bit is low and `osc_stop` and `vco_stop` are 0. After reset, with all run bits 1 and the power-down input high, every output toggles at its source frequency.
- R2: A power-down input that is low for only one CPU-clock rising edge is not accepted. `osc_stop` stays 0 and every enabled output keeps toggling.
- R3: When the power-down input is low on two consecutive CPU-clock (`clk_src[0]`) rising edges, power-down is accepted, and `osc_stop` and `vco_stop` both become 1.
- R4: While power-down is accepted, every `clk_out` bit stays low, including the free-running output.
- R5: Every high pulse on `clk_out[i]` lasts exactly the high phase of `clk_src[i]`. This holds across power-down entry, power-down exit, run-bit changes and reset release.
- R6: `out_en[i]` = 1 lets output i run. `out_en[i]` = 0 holds `clk_out[i]` low with no edges. Bit i of `out_en` controls bit i of `clk_out`.
- R7: The output at index `FREE_IDX` (default 2, the free-running memory clock) runs whatever its `out_en` bit holds.
- R8: `tri_all` = 1 drives every `clk_oe` bit to 0 (pins floated). `tri_all` = 0 drives every `clk_oe` bit to 1.
- R9: When the power-down input returns high, `osc_stop` and `vco_stop` return to 0, and every enabled output toggles again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | NUM_OUT | Source clocks; bit 0 is the CPU clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of the slowest source |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| out_en | input | NUM_OUT | Per-output run bits, 1 = running |
| tri_all | input | 1 | 1 = float all output pins |
| clk_out | output | NUM_OUT | Gated clocks |
| clk_oe | output | NUM_OUT | Per-pin drive enables, 1 = driven |
| osc_stop | output | 1 | Request to stop the crystal oscillator |
| vco_stop | output | 1 | Request to stop the VCOs |

## Verification
The bench measures the width of every high pulse on every output against its source's half period. A gate that switched while its clock was high would show up as a runt pulse at power-down entry, at release, or when a run bit changes. A power-down request held low for exactly one CPU sample is sent on its own; a qualifier that accepts a single low sample would raise `osc_stop` and silence the outputs. A sweep of run-bit patterns confirms that each bit parks only its own output and that the free-running output ignores its bit; a wrong index map or a missing exemption would stop or free the wrong pin.

// File: rtl/clk_park_pkg.sv
package clk_park_pkg;

    localparam int NUM_OUT_DEF  = 8;
    localparam int SYNC_DEF     = 2;
    localparam int QUAL_DEF     = 2;

    typedef enum logic [2:0] {
        OUT_CPU   = 3'd0,
        OUT_MEM   = 3'd1,
        OUT_MEMF  = 3'd2,
        OUT_HUB   = 3'd3,
        OUT_BUS   = 3'd4,
        OUT_IRQ   = 3'd5,
        OUT_USB   = 3'd6,
        OUT_REF   = 3'd7
    } out_id_e;

    typedef struct packed {
        logic run_req;
        logic park_req;
    } gate_ctl_t;

    function automatic logic is_free(input int idx, input int free_idx);
        return (idx == free_idx);
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pd_qualify.sv
module pd_qualify #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_COUNT  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    output logic accept
);
    localparam int CW = $clog2(QUAL_COUNT + 1);

    logic          pd_n_s;
    logic [CW-1:0] low_cnt;

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
        .clk (clk),
        .rst (rst),
        .d   (pd_n),
        .q   (pd_n_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            accept  <= 1'b0;
        end else begin
            if (pd_n_s)
                low_cnt <= '0;
            else if (low_cnt != CW'(QUAL_COUNT))
                low_cnt <= low_cnt + 1'b1;
            accept <= !pd_n_s && (low_cnt >= CW'(QUAL_COUNT - 1));
        end
    end

    // R3: acceptance needs a low synchronised sample in the previous cycle
    p_accept_needs_low_r3: assert property (@(posedge clk) disable iff (rst)
        accept |-> !$past(pd_n_s));

    // R9: a high synchronised sample withdraws acceptance on the next cycle
    p_release_drops_r9: assert property (@(posedge clk) disable iff (rst)
        pd_n_s |=> !accept);
endmodule

// File: rtl/out_gate.sv
module out_gate
    import clk_park_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic FREE_RUN    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pd_req,
    output logic clk_out
);
    gate_ctl_t ctl;
    logic      en_s;
    logic      pd_s;
    logic      gate;

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk (clk), .rst (rst), .d (en), .q (en_s)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
        .clk (clk), .rst (rst), .d (pd_req), .q (pd_s)
    );

    always_comb begin
        ctl.park_req = pd_s;
        ctl.run_req  = FREE_RUN | en_s;
    end

    // gate moves only at the falling edge, while the source is low
    always_ff @(negedge clk) begin
        if (rst) gate <= 1'b0;
        else     gate <= ctl.run_req && !ctl.park_req;
    end

    assign clk_out = clk & gate;

    // R4: a power-down request held over a full cycle keeps the gate closed
    p_pd_parks_r4: assert property (@(negedge clk) disable iff (rst)
        (pd_s && $past(pd_s)) |-> !gate);

    // R6: a run bit held low over a full cycle keeps a non-free gate closed
    p_disabled_parks_r6: assert property (@(negedge clk) disable iff (rst)
        (!FREE_RUN && !en_s && $past(!en_s)) |-> !gate);
endmodule

// File: rtl/clk_park_ctrl.sv
module clk_park_ctrl
    import clk_park_pkg::*;
#(
    parameter int NUM_OUT     = NUM_OUT_DEF,
    parameter int FREE_IDX    = int'(OUT_MEMF),
    parameter int SYNC_STAGES = SYNC_DEF,
    parameter int QUAL_COUNT  = QUAL_DEF
) (
    input  logic [NUM_OUT-1:0] clk_src,
    input  logic               rst,
    input  logic               pd_n,
    input  logic [NUM_OUT-1:0] out_en,
    input  logic               tri_all,
    output logic [NUM_OUT-1:0] clk_out,
    output logic [NUM_OUT-1:0] clk_oe,
    output logic               osc_stop,
    output logic               vco_stop
);
    localparam int CPU_IDX = int'(OUT_CPU);

    logic pd_accept;

    pd_qualify #(.SYNC_STAGES(SYNC_STAGES), .QUAL_COUNT(QUAL_COUNT)) u_qual (
        .clk    (clk_src[CPU_IDX]),
        .rst    (rst),
        .pd_n   (pd_n),
        .accept (pd_accept)
    );

    assign osc_stop = pd_accept;
    assign vco_stop = pd_accept;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        out_gate #(
            .SYNC_STAGES (SYNC_STAGES),
            .FREE_RUN    (is_free(g, FREE_IDX))
        ) u_gate (
            .clk     (clk_src[g]),
            .rst     (rst),
            .en      (out_en[g]),
            .pd_req  (pd_accept),
            .clk_out (clk_out[g])
        );
    end

    assign clk_oe = {NUM_OUT{~tri_all}};

    // R1: the CPU output is silent during reset
    p_reset_quiet_r1: assert property (@(posedge clk_src[CPU_IDX])
        rst |=> (!clk_out[CPU_IDX] && !osc_stop));

    // R8: pin drive follows the global float bit
    always_comb begin
        p_float_r8: assert (clk_oe == (tri_all ? '0 : '1));
    end
endmodule

// File: tb/clk_park_ctrl_tb.sv
`timescale 1ns/1ps
module clk_park_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int FREE       = 2;
    localparam int PER [N]    = '{CLK_PERIOD, 8, 8, 14, 28, 56, 22, 70};

    logic [N-1:0] clk_src = '0;
    logic         rst     = 1'b1;
    logic         pd_n    = 1'b1;
    logic [N-1:0] out_en  = '1;
    logic         tri_all = 1'b0;
    logic [N-1:0] clk_out;
    logic [N-1:0] clk_oe;
    logic         osc_stop;
    logic         vco_stop;

    int checks = 0;
    int fails  = 0;
    int rise_cnt [N];
    int wchk [N];
    int wbad [N];
    int snap [N];
    logic stop_seen = 1'b0;

    clk_park_ctrl u_dut (
        .clk_src (clk_src), .rst (rst), .pd_n (pd_n), .out_en (out_en),
        .tri_all (tri_all), .clk_out (clk_out), .clk_oe (clk_oe),
        .osc_stop (osc_stop), .vco_stop (vco_stop)
    );

    for (genvar g = 0; g < N; g++) begin : g_mon
        int      rl = 0;
        int      wc = 0;
        int      wb = 0;
        realtime tr = -1.0;
        initial forever #(PER[g] / 2) clk_src[g] = ~clk_src[g];
        always @(posedge clk_out[g]) begin
            rl++;
            tr = $realtime;
        end
        // R5: each high pulse equals the source high phase
        always @(negedge clk_out[g]) begin
            if (tr >= 0.0) begin
                wc++;
                if (($realtime - tr) > (PER[g] / 2.0) + 0.01 ||
                    ($realtime - tr) < (PER[g] / 2.0) - 0.01) begin
                    wb++;
                    $display("FAIL R5 out%0d pulse width %0.3f expected %0.3f",
                             g, $realtime - tr, PER[g] / 2.0);
                end
            end
        end
        assign rise_cnt[g] = rl;
        assign wchk[g]     = wc;
        assign wbad[g]     = wb;
    end

    always @(posedge osc_stop) stop_seen = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < N; i++) snap[i] = rise_cnt[i];
    endtask

    // run window, then compare each output's activity with expected mask
    task automatic window_check(input logic [N-1:0] exp_run, input string req);
        take_snap();
        #400;
        for (int i = 0; i < N; i++) begin
            int d = rise_cnt[i] - snap[i];
            check(exp_run[i] ? (d > 0) : (d == 0), req, $sformatf("out%0d rises", i),
                  d, exp_run[i] ? 1 : 0);
        end
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        #100;
        window_check('0, "R1");
        check(osc_stop == 1'b0 && vco_stop == 1'b0, "R1", "stop reqs in reset",
              {osc_stop, vco_stop}, 0);
        @(negedge clk_src[0]);
        rst = 1'b0;
        #400;
        window_check('1, "R1");
        // R8 float control
        #3;
        check(clk_oe == '1, "R8", "oe with tri_all=0", clk_oe, 8'hFF);
        tri_all = 1'b1;
        #3;
        check(clk_oe == '0, "R8", "oe with tri_all=1", clk_oe, 0);
        tri_all = 1'b0;
        #3;
        check(clk_oe == '1, "R8", "oe restored", clk_oe, 8'hFF);
        // R6 / R7 sweep: walking zero, all zero, alternating, all one
        for (int p = 0; p < N + 3; p++) begin
            logic [N-1:0] pat;
            logic [N-1:0] exp;
            if (p < N)           pat = ~(8'b1 << p);
            else if (p == N)     pat = '0;
            else if (p == N + 1) pat = 8'hA5;
            else                 pat = '1;
            out_en = pat;
            exp    = pat | (8'b1 << FREE);
            #500;
            window_check(exp, (p == FREE || p == N) ? "R7" : "R6");
        end
        // R2 single-sample power-down pulse is ignored
        #200;
        stop_seen = 1'b0;
        @(negedge clk_src[0]);
        pd_n = 1'b0;
        @(negedge clk_src[0]);
        pd_n = 1'b1;
        #400;
        check(stop_seen == 1'b0, "R2", "osc_stop after one-sample pulse", stop_seen, 0);
        window_check('1, "R2");
        // R3 / R4 accepted power-down
        @(negedge clk_src[0]);
        pd_n = 1'b0;
        #700;
        check(osc_stop == 1'b1, "R3", "osc_stop in power-down", osc_stop, 1);
        check(vco_stop == 1'b1, "R3", "vco_stop in power-down", vco_stop, 1);
        window_check('0, "R4");
        check(clk_out == '0, "R4", "outputs level in power-down", clk_out, 0);
        // R9 release
        pd_n = 1'b1;
        #700;
        check(osc_stop == 1'b0 && vco_stop == 1'b0, "R9", "stop reqs after release",
              {osc_stop, vco_stop}, 0);
        window_check('1, "R9");
        // R5 summary of pulse-width checks
        #200;
        for (int i = 0; i < N; i++) begin
            checks += wchk[i];
            check(wbad[i] == 0 && wchk[i] > 0, "R5", $sformatf("out%0d runt pulses", i),
                  wbad[i], 0);
            fails += wbad[i];
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule